// File: doc/BRIEF.md
# Sized-transfer APB requester

This block sits between a simple processor-side request port and a single APB completer. The processor raises a go strobe together with a direction, an access size (word, halfword or byte) and a 32-bit address and write value; the block then runs the APB handshake with a one-cycle select phase followed by an enable phase. It stays in the enable phase until the completer reports ready. It then hands back the read value and the error flag, together with a one-cycle completion pulse.

Narrow accesses are handled inside the block. The byte-lane strobes are derived from the size code and the two lowest address bits. Write values are moved onto the addressed lanes, and read values are taken from those lanes and zero-extended. If go is still high when a transfer finishes, the next transfer begins its select phase on the very next cycle, with no idle cycle between the two. This gives back-to-back bursts.

Top module: `apb_sized_requester`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and afterwards until a request arrives, `psel`, `penable` and `cpu_done` are low.
- R2: With the bus idle, a high `cpu_go` sampled on a rising edge captures the request: from that edge `psel` is high, `penable` is low, and `paddr` equals `cpu_addr` unchanged.
- R3: The select-only phase lasts exactly one cycle and is followed by the enable phase (`psel` and `penable` high). `paddr`, `pwrite`, `pwdata` and `pstrb` do not change between the two phases, and `penable` is never high without `psel`.
- R4: While `pready` is low in the enable phase, `penable` stays high and the bus outputs stay unchanged.
- R5: On the rising edge where `penable` and `pready` are both high, the block registers `cpu_done` high for exactly one cycle. In that same edge it registers `cpu_err` from `pslverr`.
- R6: If `cpu_go` is high on a completing edge, the next request is captured on that edge and the cycle that follows is a select-only phase for it, with no idle cycle in between.
- R7: If `cpu_go` is low on a completing edge, `psel` and `penable` are low in the following cycle.
- R8: For a write, `pstrb` follows the size code `cpu_size`: 2'b00 (word) gives 4'b1111. 2'b01 (halfword) gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. 2'b10 (byte) gives the single bit `1 << addr[1:0]`.
- R9: For a write, `pwdata` carries the word unchanged. A halfword write puts `cpu_wdata[15:0]` in lanes 1:0 or 3:2 as chosen by address bit 1, and a byte write puts `cpu_wdata[7:0]` in lane `addr[1:0]`. All other lanes are zero. Lane n is bits 8n+7 to 8n.
- R10: For a read, `pstrb` is 4'b0000, and `cpu_rdata` is the selected lanes of `prdata` moved down to bit 0 and zero-extended: the whole word, the halfword picked by address bit 1, or the byte picked by address bits 1:0.
- R11: `pwrite` is high for a write and low for a read, as given by `cpu_write` when the request is captured.
- R12: The unused size code 2'b11 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_go | input | 1 | Request strobe; held high to chain transfers |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 word, 01 halfword, 10 byte, 11 treated as word |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write value, right-aligned for narrow sizes |
| cpu_rdata | output | 32 | Read value, zero-extended for narrow sizes |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Error flag captured at completion |
| paddr | output | 32 | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data, lane-aligned |
| pstrb | output | 4 | APB byte-lane strobes |
| pready | input | 1 | APB ready from the completer |
| prdata | input | 32 | APB read data |
| pslverr | input | 1 | APB error from the completer |

## Verification
A wrong phase register shows at `psel`/`penable` one cycle after the bad edge. Examples are a select phase that lasts two cycles, an enable phase that ends without ready, or an idle gap inside a burst. A wrong captured size or address shows up already in the select phase, as a wrong strobe or lane placement, one cycle after the request. On reads it also shows in `cpu_rdata` on the cycle of the completion pulse. The sweep covers every size code, every low address pair and both directions, with varied wait states. A burst checks that a request changing during the enable phase does not disturb the bus.

// File: rtl/apbreq_pkg.sv
package apbreq_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETUP  = 2'b01,
    PH_ACCESS = 2'b10
  } phase_e;

  // Byte-lane mask for an access of the given size at the given low address.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                 input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (size_e'(size))
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      SZ_BYTE: m = 4'b0001 << lo;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // Moves right-aligned write data onto the addressed lanes.
  function automatic logic [DATA_W-1:0] place_wdata(input logic [1:0] size,
                                                    input logic [1:0] lo,
                                                    input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    case (size_e'(size))
      SZ_HALF: r = lo[1] ? {d[15:0], 16'h0000} : {16'h0000, d[15:0]};
      SZ_BYTE: r = {24'h000000, d[7:0]} << {lo, 3'b000};
      default: r = d;
    endcase
    return r;
  endfunction

  // Pulls the addressed lanes down to bit 0 and zero-extends them.
  function automatic logic [DATA_W-1:0] pick_rdata(input logic [1:0] size,
                                                   input logic [1:0] lo,
                                                   input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] sh;
    sh = d >> {lo, 3'b000};
    case (size_e'(size))
      SZ_HALF: r = lo[1] ? {16'h0000, d[31:16]} : {16'h0000, d[15:0]};
      SZ_BYTE: r = {24'h000000, sh[7:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/apbreq_fsm.sv
module apbreq_fsm
  import apbreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic pready,
  output logic psel,
  output logic penable,
  output logic load,
  output logic finish
);

  phase_e phase_q, phase_d;

  assign finish = (phase_q == PH_ACCESS) && pready;
  assign load   = go && ((phase_q == PH_IDLE) || finish);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (go) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: if (pready) phase_d = go ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign psel    = (phase_q != PH_IDLE);
  assign penable = (phase_q == PH_ACCESS);

  AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_ACCESS)); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ACCESS) && !pready) |=> (phase_q == PH_ACCESS)); // R4
  AST_CHAIN_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && go) |=> (phase_q == PH_SETUP)); // R6
  AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !go) |=> (phase_q == PH_IDLE)); // R7

endmodule

// File: rtl/apbreq_lane.sv
module apbreq_lane
  import apbreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] wdata_raw,
  input  logic [DATA_W-1:0] rdata_bus,
  output logic [LANES-1:0]  strb,
  output logic [DATA_W-1:0] wdata_bus,
  output logic [DATA_W-1:0] rdata_out
);

  logic [LANES-1:0] mask;

  assign mask      = lane_mask(size, lo);
  assign strb      = write ? mask : '0;
  assign wdata_bus = place_wdata(size, lo, wdata_raw);
  assign rdata_out = pick_rdata(size, lo, rdata_bus);

  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !write) |-> (strb == '0)); // R10
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (active && write) |-> ($countones(strb) == 1 || $countones(strb) == 2 ||
                           $countones(strb) == 4)); // R8

endmodule

// File: rtl/apb_sized_requester.sv
module apb_sized_requester
  import apbreq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_go,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [LANES-1:0]  pstrb,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);

  logic              load, finish;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wraw_q;
  logic [DATA_W-1:0] rshaped;

  apbreq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (cpu_go),
    .pready  (pready),
    .psel    (psel),
    .penable (penable),
    .load    (load),
    .finish  (finish)
  );

  // Request capture: only on entry to SETUP, so the bus holds through ACCESS.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      size_q <= 2'b00;
      wraw_q <= '0;
    end else if (load) begin
      paddr  <= cpu_addr;
      pwrite <= cpu_write;
      size_q <= cpu_size;
      wraw_q <= cpu_wdata;
    end
  end

  apbreq_lane u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (psel),
    .write     (pwrite),
    .size      (size_q),
    .lo        (paddr[1:0]),
    .wdata_raw (wraw_q),
    .rdata_bus (prdata),
    .strb      (pstrb),
    .wdata_bus (pwdata),
    .rdata_out (rshaped)
  );

  // Completion: pulse and result capture on the edge that ends ACCESS.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_done  <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= finish;
      if (finish) begin
        cpu_err <= pslverr;
        if (!pwrite) cpu_rdata <= rshaped;
      end
    end
  end

  AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel); // R3
  AST_SETUP_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(paddr) && $stable(pwrite) &&
                            $stable(pwdata) && $stable(pstrb))); // R3
  AST_WAIT_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (penable && $stable(paddr) && $stable(pwdata))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R5
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && pready) |=> cpu_done); // R5

endmodule

// File: tb/tb_apb_sized_requester.sv
`timescale 1ns/1ps
module tb_apb_sized_requester;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_go = 1'b0, cpu_write = 1'b0;
  logic [1:0]  cpu_size = 2'b00;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_err;
  logic [31:0] paddr, pwdata;
  logic        psel, penable, pwrite;
  logic [3:0]  pstrb;
  logic        pready = 1'b0, pslverr = 1'b0;
  logic [31:0] prdata = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  apb_sized_requester dut (
    .clk(clk), .rst_n(rst_n), .cpu_go(cpu_go), .cpu_write(cpu_write),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_err(cpu_err),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .pstrb(pstrb), .pready(pready), .prdata(prdata),
    .pslverr(pslverr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lanes touched: count of bytes and first lane, restated per size code.
  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd1) ? 2 : (sz == 2'd2) ? 1 : 4;
  endfunction
  function automatic int first_lane(input logic [1:0] sz, input logic [1:0] lo);
    return (sz == 2'd1) ? 2 * lo[1] : (sz == 2'd2) ? int'(lo) : 0;
  endfunction

  function automatic logic [3:0] exp_strb(input logic w, input logic [1:0] sz,
                                          input logic [1:0] lo);
    logic [3:0] s = '0;
    if (w) for (int k = 0; k < nbytes(sz); k++) s[first_lane(sz, lo) + k] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [1:0] lo,
                                            input logic [31:0] d);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes(sz); k++)
      r[8*(first_lane(sz, lo)+k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] sz, input logic [1:0] lo,
                                            input logic [31:0] d);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes(sz); k++)
      r[8*k +: 8] = d[8*(first_lane(sz, lo)+k) +: 8];
    return r;
  endfunction

  task automatic single(input logic w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input int waits,
                        input logic [31:0] rd, input logic er);
    @(negedge clk);
    cpu_go = 1'b1; cpu_write = w; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_go = 1'b0; cpu_addr = ~a; cpu_wdata = ~d;
    chk("R2 psel in setup", 32'(psel), 32'd1);
    chk("R2 penable low in setup", 32'(penable), 32'd0);
    chk("R2 paddr", paddr, a);
    chk("R11 pwrite", 32'(pwrite), 32'(w));
    if (w) chk("R8 R12 write strobes", 32'(pstrb), 32'(exp_strb(1'b1, sz, a[1:0])));
    else   chk("R10 read strobes zero", 32'(pstrb), 32'd0);
    if (w) chk("R9 R12 write lanes", pwdata, exp_wdata(sz, a[1:0], d));
    @(negedge clk);
    chk("R3 enable phase", 32'({psel, penable}), 32'd3);
    chk("R3 paddr held", paddr, a);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R4 wait holds enable", 32'(penable), 32'd1);
      chk("R4 wait holds strobes", 32'(pstrb), 32'(exp_strb(w, sz, a[1:0])));
      chk("R5 no done while waiting", 32'(cpu_done), 32'd0);
    end
    pready = 1'b1; prdata = rd; pslverr = er;
    @(negedge clk);
    pready = 1'b0; prdata = ~rd; pslverr = ~er;
    chk("R5 done pulse", 32'(cpu_done), 32'd1);
    chk("R5 err captured", 32'(cpu_err), 32'(er));
    if (!w) chk("R10 R12 read lanes", cpu_rdata, exp_rdata(sz, a[1:0], rd));
    chk("R7 idle after finish", 32'({psel, penable}), 32'd0);
    @(negedge clk);
    chk("R5 done one cycle", 32'(cpu_done), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #12;
    chk("R1 reset psel", 32'(psel), 32'd0);
    chk("R1 reset penable", 32'(penable), 32'd0);
    chk("R1 reset done", 32'(cpu_done), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 idle without go", 32'({psel, penable, cpu_done}), 32'd0);

    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++)
          single(w[0], sz[1:0], 32'h4000_1230 | 32'(lo) | (32'(sz) << 8),
                 32'hA1B2_C3D4 ^ (32'(lo) * 32'h0101_0101),
                 (sz + lo) % 3,
                 32'h8F6E_4D2C + 32'(sz * 4 + lo) * 32'h1111_1111,
                 lo == 3);

    // Burst: two chained transfers, request changes during ACCESS.
    @(negedge clk);
    cpu_go = 1'b1; cpu_write = 1'b0; cpu_size = 2'd2; cpu_addr = 32'h0000_0102;
    @(negedge clk);
    chk("R2 burst first setup", 32'({psel, penable}), 32'd2);
    cpu_write = 1'b1; cpu_size = 2'd1; cpu_addr = 32'h0000_0206; cpu_wdata = 32'h1234_5678;
    @(negedge clk);
    chk("R3 burst bus unaffected by new request", paddr, 32'h0000_0102);
    chk("R3 burst direction unaffected", 32'(pwrite), 32'd0);
    pready = 1'b1; prdata = 32'hDEAD_BEEF; pslverr = 1'b0;
    @(negedge clk);
    cpu_go = 1'b0; pready = 1'b0;
    chk("R6 chained setup, no idle", 32'({psel, penable}), 32'd2);
    chk("R6 second address", paddr, 32'h0000_0206);
    chk("R5 first done", 32'(cpu_done), 32'd1);
    chk("R10 first read byte lane 2", cpu_rdata, 32'h0000_00AD);
    chk("R8 second strobes", 32'(pstrb), 32'hC);
    chk("R9 second lanes", pwdata, 32'h5678_0000);
    @(negedge clk);
    chk("R5 done gap", 32'(cpu_done), 32'd0);
    chk("R3 second enable", 32'({psel, penable}), 32'd3);
    pready = 1'b1; pslverr = 1'b1;
    @(negedge clk);
    pready = 1'b0; pslverr = 1'b0;
    chk("R5 second err", 32'(cpu_err), 32'd1);
    chk("R7 burst ends idle", 32'({psel, penable}), 32'd0);
    chk("R10 write leaves read result", cpu_rdata, 32'h0000_00AD);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule